// File: doc/BRIEF.md
# Planar Video Memory Access Controller

This block connects a byte-wide host memory port to four byte-wide video memory planes. Four small registers decide how each host access is decoded. They are reached through two index/data port pairs, one for the sequencer group and one for the graphics group. The decode covers two address schemes: linear planar addressing, where every plane sees the host address unchanged, and odd/even addressing, where host address bit 0 picks a pair of planes and the remaining bits form the plane offset.

A host read loads all four plane latches from one plane offset and returns one of the four bytes. A host write stores either the host byte (write mode 0) or the latched bytes (write mode 1) into the planes that are enabled. Write mode 1 carries the fast block copies used to scroll the screen: a read at a source offset followed by a write at a destination offset moves all four planes in one pass.

Only the sequencer's linear-addressing bit switches address steering. The odd/even bit in the graphics mode register is stored and can be read back, but it has no effect on the decode. A mode that sets that bit while leaving linear addressing selected therefore still copies data linearly.

Top module: `planar_vmem_ctrl`

## Requirements
- R1: After reset the sequencer index, graphics index, memory-mode, read-map, graphics-mode and miscellaneous registers read 0 and the map mask reads 0x0F. An index port keeps its value across writes to its data port.
- R2: Register access uses reg_sel 0 (sequencer index), 1 (sequencer data), 2 (graphics index) and 3 (graphics data). Sequencer index 2 is the map mask, which keeps bits 3:0; upper bits read 0. Sequencer index 4 is the memory mode. Graphics index 4 is the read-map select, which keeps bits 1:0. Graphics index 5 is the mode register, with its odd/even bit at bit 4; it is fully readable and writable. Graphics index 6 is the miscellaneous register. Every other index reads 0 and ignores writes.
- R3: When memory-mode bit 2 is 0, writes use odd/even steering. An even host address writes planes 0 and 2, an odd host address writes planes 1 and 3, and the plane offset is the host address shifted right by one.
- R4: When memory-mode bit 2 is 1, a write reaches every plane enabled by the map mask at an offset equal to the host address. This holds even when graphics-mode bit 4 is set.
- R5: A plane whose map-mask bit is 0 is never written, in any mode.
- R6: Graphics-mode bits 1:0 select the write mode. Values 0, 2 and 3 act as write mode 0: the host byte is written unchanged to each enabled plane. No write ever changes the latches.
- R7: In write mode 1 (bits 1:0 equal to 1), each enabled plane p receives latch byte p and the host data is ignored. A read at offset a+80 followed by a write at offset a therefore moves a scan line up by one line of 80 bytes.
- R8: With linear read decoding, mem_rvalid is high exactly one cycle after an accepted read. mem_rdata is then the byte of the plane chosen by read-map bits 1:0, at the host address, and all four latches are loaded from that offset.
- R9: Reads use odd/even decoding when memory-mode bit 2 is 0 or when miscellaneous bit 1 (chain) is 1. In that case the returned plane is host address bit 0 (plane 0 or plane 1) and the offset is the host address shifted right by one.
- R10: When mem_wr and mem_rd are high in the same cycle, the write is performed and the read is dropped: there is no mem_rvalid and the latches keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Register port select: 0 seq index, 1 seq data, 2 gfx index, 3 gfx data |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for the selected port (combinational) |
| mem_wr | input | 1 | Host memory write strobe |
| mem_rd | input | 1 | Host memory read strobe |
| mem_addr | input | PLANE_AW | Host byte address |
| mem_wdata | input | 8 | Host write byte |
| mem_rdata | output | 8 | Host read byte, valid with mem_rvalid |
| mem_rvalid | output | 1 | High one cycle after an accepted read |

## Verification
The bench builds the block with PLANE_AW = 8, which gives 256 bytes per plane. That is enough room to hold a source scan line at offset 160 and copy it, 80 bytes lower, into a separate destination region. It also leaves separate odd/even offset windows for the vector table. Because every plane can be cleared in 256 cycles, unwritten planes read a known zero, so writes that must be blocked by the map mask or by plane-pair steering show up as zero bytes on readback.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_PLANES = 4;
    localparam int PSEL_W     = $clog2(NUM_PLANES);

    localparam logic [1:0] SEL_SEQ_IDX = 2'd0;
    localparam logic [1:0] SEL_SEQ_DAT = 2'd1;
    localparam logic [1:0] SEL_GFX_IDX = 2'd2;
    localparam logic [1:0] SEL_GFX_DAT = 2'd3;

    localparam logic [7:0] IDX_MAP_MASK = 8'd2;
    localparam logic [7:0] IDX_MEM_MODE = 8'd4;
    localparam logic [7:0] IDX_RD_MAP   = 8'd4;
    localparam logic [7:0] IDX_GMODE    = 8'd5;
    localparam logic [7:0] IDX_GMISC    = 8'd6;

    localparam int MEMMODE_LINEAR_BIT = 2;
    localparam int GMODE_OE_BIT       = 4;
    localparam int GMISC_CHAIN_BIT    = 1;

    localparam logic [NUM_PLANES-1:0] MASK_RESET = '1;

    typedef logic [NUM_PLANES-1:0][BYTE_W-1:0] plane_bytes_t;

    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_LATCH  = 2'd1,
        WM_RSVD2  = 2'd2,
        WM_RSVD3  = 2'd3
    } write_mode_e;

    typedef struct packed {
        logic [7:0]            seq_idx;
        logic [NUM_PLANES-1:0] map_mask;
        logic [7:0]            mem_mode;
        logic [7:0]            gfx_idx;
        logic [PSEL_W-1:0]     read_map;
        logic [7:0]            gfx_mode;
        logic [7:0]            gfx_misc;
    } pvm_regs_t;

endpackage

// File: rtl/pvm_regfile.sv
module pvm_regfile
    import pvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output pvm_regs_t  regs
);

    pvm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_SEQ_IDX: regs_d.seq_idx = reg_wdata;
                SEL_SEQ_DAT: begin
                    if (regs_q.seq_idx == IDX_MAP_MASK)
                        regs_d.map_mask = reg_wdata[NUM_PLANES-1:0];
                    else if (regs_q.seq_idx == IDX_MEM_MODE)
                        regs_d.mem_mode = reg_wdata;
                end
                SEL_GFX_IDX: regs_d.gfx_idx = reg_wdata;
                SEL_GFX_DAT: begin
                    if (regs_q.gfx_idx == IDX_RD_MAP)
                        regs_d.read_map = reg_wdata[PSEL_W-1:0];
                    else if (regs_q.gfx_idx == IDX_GMODE)
                        regs_d.gfx_mode = reg_wdata;
                    else if (regs_q.gfx_idx == IDX_GMISC)
                        regs_d.gfx_misc = reg_wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_SEQ_IDX: reg_rdata = regs_q.seq_idx;
            SEL_SEQ_DAT: begin
                if (regs_q.seq_idx == IDX_MAP_MASK)
                    reg_rdata = {{(8-NUM_PLANES){1'b0}}, regs_q.map_mask};
                else if (regs_q.seq_idx == IDX_MEM_MODE)
                    reg_rdata = regs_q.mem_mode;
            end
            SEL_GFX_IDX: reg_rdata = regs_q.gfx_idx;
            SEL_GFX_DAT: begin
                if (regs_q.gfx_idx == IDX_RD_MAP)
                    reg_rdata = {{(8-PSEL_W){1'b0}}, regs_q.read_map};
                else if (regs_q.gfx_idx == IDX_GMODE)
                    reg_rdata = regs_q.gfx_mode;
                else if (regs_q.gfx_idx == IDX_GMISC)
                    reg_rdata = regs_q.gfx_misc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.map_mask <= MASK_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

    // R1: a data-port write leaves the matching index untouched
    p_seq_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_SEQ_DAT) |=> $stable(regs_q.seq_idx));
    p_gfx_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_GFX_DAT) |=> $stable(regs_q.gfx_idx));

endmodule

// File: rtl/pvm_steer.sv
module pvm_steer
    import pvm_pkg::*;
#(
    parameter int PLANE_AW = 8
) (
    input  pvm_regs_t             regs,
    input  logic                  mem_wr,
    input  logic                  mem_rd,
    input  logic [PLANE_AW-1:0]   mem_addr,
    input  logic [7:0]            mem_wdata,
    input  plane_bytes_t          latches,
    output logic [NUM_PLANES-1:0] plane_we,
    output logic [PLANE_AW-1:0]   plane_addr,
    output plane_bytes_t          plane_wdata,
    output logic                  rd_accept,
    output logic [PSEL_W-1:0]     rd_plane
);

    localparam logic [NUM_PLANES-1:0] EVEN_PAIR = 4'b0101;
    localparam logic [NUM_PLANES-1:0] ODD_PAIR  = 4'b1010;

    logic                  oe_write;
    logic                  oe_read;
    logic [NUM_PLANES-1:0] pair_mask;
    logic [PLANE_AW-1:0]   half_addr;
    write_mode_e           wmode;

    always_comb begin
        wmode     = write_mode_e'(regs.gfx_mode[1:0]);
        half_addr = mem_addr >> 1;
        oe_write  = !regs.mem_mode[MEMMODE_LINEAR_BIT];
        oe_read   = !regs.mem_mode[MEMMODE_LINEAR_BIT] || regs.gfx_misc[GMISC_CHAIN_BIT];

        if (oe_write)
            pair_mask = mem_addr[0] ? ODD_PAIR : EVEN_PAIR;
        else
            pair_mask = '1;

        plane_we  = mem_wr ? (pair_mask & regs.map_mask) : '0;
        rd_accept = mem_rd && !mem_wr;

        if (mem_wr)
            plane_addr = oe_write ? half_addr : mem_addr;
        else
            plane_addr = oe_read ? half_addr : mem_addr;

        if (oe_read)
            rd_plane = PSEL_W'(mem_addr[0]);
        else
            rd_plane = regs.read_map;
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_wdata
        assign plane_wdata[p] = (wmode == WM_LATCH) ? latches[p] : mem_wdata;
    end

endmodule

// File: rtl/pvm_plane_store.sv
module pvm_plane_store
    import pvm_pkg::*;
#(
    parameter int PLANE_AW = 8
) (
    input  logic                  clk,
    input  logic [NUM_PLANES-1:0] plane_we,
    input  logic [PLANE_AW-1:0]   plane_addr,
    input  plane_bytes_t          plane_wdata,
    output plane_bytes_t          plane_rdata
);

    localparam int DEPTH = 1 << PLANE_AW;

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (plane_we[p])
                mem[plane_addr] <= plane_wdata[p];
        end

        assign plane_rdata[p] = mem[plane_addr];
    end

endmodule

// File: rtl/planar_vmem_ctrl.sv
module planar_vmem_ctrl
    import pvm_pkg::*;
#(
    parameter int PLANE_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                mem_wr,
    input  logic                mem_rd,
    input  logic [PLANE_AW-1:0] mem_addr,
    input  logic [7:0]          mem_wdata,
    output logic [7:0]          mem_rdata,
    output logic                mem_rvalid
);

    typedef struct packed {
        plane_bytes_t latch;
        logic [7:0]   rdata;
        logic         rvalid;
    } rd_state_t;

    pvm_regs_t             regs;
    plane_bytes_t          plane_wdata;
    plane_bytes_t          plane_rdata;
    logic [NUM_PLANES-1:0] plane_we;
    logic [PLANE_AW-1:0]   plane_addr;
    logic                  rd_accept;
    logic [PSEL_W-1:0]     rd_plane;
    rd_state_t             st_d, st_q;

    pvm_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .regs      (regs)
    );

    pvm_steer #(.PLANE_AW(PLANE_AW)) u_steer (
        .regs        (regs),
        .mem_wr      (mem_wr),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .latches     (st_q.latch),
        .plane_we    (plane_we),
        .plane_addr  (plane_addr),
        .plane_wdata (plane_wdata),
        .rd_accept   (rd_accept),
        .rd_plane    (rd_plane)
    );

    pvm_plane_store #(.PLANE_AW(PLANE_AW)) u_store (
        .clk         (clk),
        .plane_we    (plane_we),
        .plane_addr  (plane_addr),
        .plane_wdata (plane_wdata),
        .plane_rdata (plane_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (rd_accept) begin
            st_d.latch  = plane_rdata;
            st_d.rdata  = plane_rdata[rd_plane];
            st_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mem_rdata  = st_q.rdata;
    assign mem_rvalid = st_q.rvalid;

    // R5: no plane outside the map mask is ever written
    p_we_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~regs.map_mask) == '0);

    // R3: even host address in odd/even mode never touches planes 1 and 3
    p_even_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !regs.mem_mode[MEMMODE_LINEAR_BIT] && !mem_addr[0])
            |-> (!plane_we[1] && !plane_we[3]));

    // R4: linear mode writes exactly the map-mask planes
    p_linear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && regs.mem_mode[MEMMODE_LINEAR_BIT]) |-> (plane_we == regs.map_mask));

    // R6: writes never change the latches
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(st_q.latch));

    // R8: an accepted read answers on the next cycle
    p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr) |=> mem_rvalid);

    // R10: no answer without an accepted read
    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && !mem_wr) |=> !mem_rvalid);

endmodule

// File: tb/tb_planar_vmem_ctrl.sv
module tb_planar_vmem_ctrl;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          mem_wr = 1'b0;
    logic          mem_rd = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;
    logic          mem_rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    planar_vmem_ctrl #(.PLANE_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // fields: linear, mask, waddr, wdata, rplane, raddr, expected
    localparam logic [38:0] VEC [0:8] = '{
        {1'b1, 4'hF, 8'd10, 8'hA5, 2'd2, 8'd10, 8'hA5},
        {1'b1, 4'h5, 8'd11, 8'h3C, 2'd1, 8'd11, 8'h00},
        {1'b1, 4'h5, 8'd12, 8'h3C, 2'd2, 8'd12, 8'h3C},
        {1'b0, 4'hF, 8'd40, 8'h77, 2'd0, 8'd20, 8'h77},
        {1'b0, 4'hF, 8'd41, 8'h88, 2'd1, 8'd20, 8'h88},
        {1'b0, 4'hF, 8'd43, 8'h99, 2'd0, 8'd21, 8'h00},
        {1'b0, 4'hF, 8'd45, 8'h66, 2'd3, 8'd22, 8'h66},
        {1'b0, 4'hE, 8'd46, 8'h55, 2'd0, 8'd23, 8'h00},
        {1'b0, 4'hE, 8'd48, 8'h55, 2'd2, 8'd24, 8'h55}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel; #1;
        val = reg_rdata;
    endtask

    task automatic set_seq(input logic [7:0] idx, input logic [7:0] val);
        reg_write(2'd0, idx); reg_write(2'd1, val);
    endtask

    task automatic set_gfx(input logic [7:0] idx, input logic [7:0] val);
        reg_write(2'd2, idx); reg_write(2'd3, val);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(posedge clk); #1;
        mem_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d, output logic v);
        mem_rd = 1'b1; mem_addr = a;
        @(posedge clk); #1;
        mem_rd = 1'b0;
        d = mem_rdata; v = mem_rvalid;
    endtask

    task automatic read_plane(input logic [1:0] p, input logic [7:0] a, output logic [7:0] d);
        logic v;
        set_gfx(8'd4, {6'd0, p});
        host_read(a, d, v);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic       v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        reg_read(2'd0, r); check("R1 seq index reset", r, 8'h00);
        reg_read(2'd2, r); check("R1 gfx index reset", r, 8'h00);
        reg_read(2'd1, r); check("R1 index0 data reads 0", r, 8'h00);
        reg_write(2'd0, 8'd2); reg_read(2'd1, r); check("R1 map mask reset", r, 8'h0F);
        reg_write(2'd0, 8'd4); reg_read(2'd1, r); check("R1 mem mode reset", r, 8'h00);
        reg_write(2'd2, 8'd5); reg_read(2'd3, r); check("R1 gfx mode reset", r, 8'h00);
        reg_write(2'd2, 8'd6); reg_read(2'd3, r); check("R1 gfx misc reset", r, 8'h00);
        reg_write(2'd2, 8'd4); reg_read(2'd3, r); check("R1 read map reset", r, 8'h00);
        @(posedge clk); #1;
        check("R8 no rvalid idle", {7'd0, mem_rvalid}, 8'h00);

        // R2 register access
        set_gfx(8'd5, 8'h11); reg_read(2'd3, r); check("R2 gfx mode odd/even bit rw", r, 8'h11);
        reg_read(2'd2, r); check("R1 gfx index holds after data write", r, 8'h05);
        set_seq(8'd2, 8'hF3); reg_read(2'd1, r); check("R2 map mask width", r, 8'h03);
        reg_read(2'd0, r); check("R1 seq index holds after data write", r, 8'h02);
        set_gfx(8'd0, 8'hAB); reg_read(2'd3, r); check("R2 unused index", r, 8'h00);
        set_gfx(8'd4, 8'hFE); reg_read(2'd3, r); check("R2 read map width", r, 8'h02);

        // clear all planes (linear, mask F, write mode 0)
        set_seq(8'd4, 8'h04); set_seq(8'd2, 8'h0F); set_gfx(8'd5, 8'h00);
        for (int a = 0; a < 256; a++) host_write(8'(a), 8'h00);

        // vector table: R3 R4 R5
        for (int i = 0; i < 9; i++) begin
            logic [38:0] e;
            e = VEC[i];
            set_seq(8'd4, e[38] ? 8'h04 : 8'h00);
            set_seq(8'd2, {4'd0, e[37:34]});
            host_write(e[33:26], e[25:18]);
            set_seq(8'd4, 8'h04);
            read_plane(e[17:16], e[15:8], r);
            check($sformatf("R3/R4/R5 vector %0d", i), r, e[7:0]);
        end
        set_seq(8'd2, 8'h0F);

        // R4: graphics odd/even bit alone keeps linear decode
        set_gfx(8'd5, 8'h10);
        host_write(8'd50, 8'h12);
        set_gfx(8'd5, 8'h00);
        read_plane(2'd3, 8'd50, r); check("R4 gfx oe bit ignored linear", r, 8'h12);
        read_plane(2'd0, 8'd25, r); check("R4 gfx oe bit ignored no half", r, 8'h00);

        // R8 read valid
        set_gfx(8'd4, 8'd2);
        host_read(8'd10, r, v);
        check("R8 rvalid", {7'd0, v}, 8'h01);
        check("R8 rdata plane 2", r, 8'hA5);
        @(posedge clk); #1;
        check("R8 rvalid single cycle", {7'd0, mem_rvalid}, 8'h00);

        // R9 chain bit forces odd/even read
        set_gfx(8'd4, 8'd0); set_gfx(8'd6, 8'h02);
        host_read(8'd41, r, v); check("R9 chain odd reads plane1", r, 8'h88);
        set_gfx(8'd6, 8'h00);
        host_read(8'd41, r, v); check("R9 chain off linear", r, 8'h00);
        set_seq(8'd4, 8'h00);
        host_read(8'd40, r, v); check("R9 oe even reads plane0", r, 8'h77);
        host_read(8'd45, r, v); check("R9 oe odd reads plane1", r, 8'h66);
        set_seq(8'd4, 8'h04);

        // R7 scroll copy: source line at 160, destination 80 below
        for (int p = 0; p < 4; p++) begin
            set_seq(8'd2, 8'(1 << p));
            for (int i = 0; i < 4; i++) host_write(8'(160 + i), 8'(16 * (p + 1) + i));
        end
        set_seq(8'd2, 8'h0F); set_gfx(8'd5, 8'h01);
        for (int i = 0; i < 4; i++) begin
            host_read(8'(160 + i), r, v);
            host_write(8'(80 + i), 8'hEE);
        end
        host_read(8'd163, r, v);
        set_seq(8'd2, 8'h01);
        host_write(8'd90, 8'hEE);
        set_seq(8'd2, 8'h0F); set_gfx(8'd5, 8'h00);
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 4; i++) begin
                read_plane(2'(p), 8'(80 + i), r);
                check($sformatf("R7 scroll plane %0d byte %0d", p, i), r, 8'(16 * (p + 1) + i));
            end
        read_plane(2'd0, 8'd90, r); check("R7 latch copy masked plane0", r, 8'h13);
        read_plane(2'd1, 8'd90, r); check("R5 latch copy blocked plane1", r, 8'h00);

        // R6 writes leave latches alone; write mode 2 acts as mode 0
        host_read(8'd160, r, v);
        host_write(8'd200, 8'h5A);
        set_gfx(8'd5, 8'h01); host_write(8'd201, 8'h00); set_gfx(8'd5, 8'h00);
        read_plane(2'd2, 8'd201, r); check("R6 latches unchanged by write", r, 8'h30);
        read_plane(2'd2, 8'd200, r); check("R6 direct write data", r, 8'h5A);
        set_gfx(8'd5, 8'h02); host_write(8'd220, 8'h4D); set_gfx(8'd5, 8'h00);
        read_plane(2'd1, 8'd220, r); check("R6 mode 2 acts direct", r, 8'h4D);

        // R10 simultaneous write and read
        host_read(8'd160, r, v);
        mem_wr = 1'b1; mem_rd = 1'b1; mem_addr = 8'd210; mem_wdata = 8'h31;
        @(posedge clk); #1;
        mem_wr = 1'b0; mem_rd = 1'b0;
        check("R10 read dropped", {7'd0, mem_rvalid}, 8'h00);
        set_gfx(8'd5, 8'h01); host_write(8'd211, 8'h00); set_gfx(8'd5, 8'h00);
        read_plane(2'd0, 8'd211, r); check("R10 latches kept", r, 8'h10);
        read_plane(2'd0, 8'd210, r); check("R10 write performed", r, 8'h31);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule